// File: doc/BRIEF.md
# Relocatable Memory-Mapped IDE Data Window

This block is a second address decoder that places a drive's 16-bit data register inside a 1 KB window of ISA memory space. It sits next to the ordinary port decoder, which handles the task file through I/O cycles. A byte-wide page register, written through an I/O port at the card's base plus 0Fh, gives the value that ISA address bits A19..A12 must equal for the window to respond. The window is live only while that register's top bit is set. This keeps the window in the upper half of the 1 MB space, where it cannot collide with the port decoder, which needs A19 low.

Inside the window, address bit A9 splits the space into a read half (offsets 000h–1FFh) and a write half (offsets 200h–3FFh). Address bit A0 chooses between a real drive transfer and a no-op cycle, and A9 reverses its sense. As a result, ascending byte pairs stream whole words through the shared byte-pair latch in the same order the port path uses. Block string moves starting at offset 000h (reads) or 200h (writes) therefore move sector data without extra software steps. While the window matches, the drive address lines are forced to zero so that every access lands on the data register. Otherwise the port path's drive address passes through unchanged.

Top module: `mmio_ide_window`

## Requirements
- R1: After reset the page register holds 00h, so no memory access hits the window until a page with its top bit set is loaded.
- R2: An I/O write whose address bits A9..A0 equal base+0Fh (300h+0Fh = 30Fh by default) loads the page register from the data byte at the next clock edge. An I/O write to any other address leaves the page register, and so the window location, unchanged.
- R3: While the page register's top bit (bit 7) is 0, the window never hits, even when A19..A12 equal the loaded value.
- R4: A hit requires A19..A12 to equal the page register and A11..A10 to be 00. With D8h loaded, the window covers D8000h–D83FFh and nothing outside that range.
- R5: In the read half (A9=0) only a memory read hits, and in the write half (A9=1) only a memory write hits. A memory write to the read half, or a memory read from the write half, does not hit.
- R6: A hit needs a memory read or memory write strobe. An I/O write, or no strobe at all, never produces a hit.
- R7: On a hit, a real data transfer is driven (cs0N=0, cs1N=1) when A0 equals A9, and a no-op is driven (cs0N=1, cs1N=0) when A0 differs from A9. An even read is therefore a transfer, an odd read a no-op, an even write a no-op and an odd write a transfer.
- R8: On a hit, ideDa is 000. Without a hit, ideDa equals portDa.
- R9: On a hit, latchLoad is 1 for an even address (A0=0), and latchDrive is 1 for an odd address (A0=1). Never are both set at once.
- R10: Without a hit, cs0N and cs1N are both 1 and latchLoad and latchDrive are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the page register |
| rstN | input | 1 | Active-low synchronous reset |
| isaAddr | input | 20 | ISA address bus A19..A0 |
| ioData | input | 8 | ISA data byte for page register loads |
| memRd | input | 1 | Memory read strobe, active high |
| memWr | input | 1 | Memory write strobe, active high |
| ioWr | input | 1 | I/O write strobe, active high |
| portDa | input | 3 | Drive address from the port decoder |
| cs0N | output | 1 | Drive command-block select, active low |
| cs1N | output | 1 | Drive control-block select, active low |
| ideDa | output | 3 | Drive address lines |
| latchLoad | output | 1 | Capture a byte into the byte-pair latch |
| latchDrive | output | 1 | Drive the latched byte onto its bus |
| windowHit | output | 1 | Window matched for this access |

## Verification
The bench builds the block with its default parameters: a 20-bit address, an 8-bit page compared against A19..A12, a 1 KB window and I/O base 300h. This leaves a two-bit gap (A11..A10) between the page compare and the window offset, so the bench can probe addresses that match the page but fall outside the window. The top bit of the page sets the enable, so pages with it clear and with it set can both be loaded and compared. The read and write halves, the A0 ordering inside each half, the opposite-direction strobes and a full 10-bit I/O decode that rejects a neighbouring port can all be reached with this build.

// File: rtl/mmio_ide_window_pkg.sv
package mmio_ide_window_pkg;

  // Strobes from the cycle classifier to the page/select datapath.
  typedef struct packed {
    logic pageLoad;   // I/O write addressed to the page register
    logic dirOk;      // memory strobe agrees with the addressed half
    logic writeHalf;  // address falls in the upper (write) half
    logic oddByte;    // address bit 0
  } winStrobe_t;

endpackage

// File: rtl/mmio_ide_window_ctrl.sv
module mmio_ide_window_ctrl
  import mmio_ide_window_pkg::*;
#(
  parameter int IO_W = 10,
  parameter logic [IO_W-1:0] REG_ADDR = 10'h30F
) (
  input  logic [IO_W-1:0] ioAddr,
  input  logic            halfSel,
  input  logic            byteSel,
  input  logic            memRd,
  input  logic            memWr,
  input  logic            ioWr,
  output winStrobe_t      strb
);

  logic regAddrEq;
  logic readHalfOk;
  logic writeHalfOk;

  always_comb begin
    regAddrEq   = (ioAddr == REG_ADDR);
    // Each half answers only the strobe of its own direction.
    readHalfOk  = memRd && !halfSel;
    writeHalfOk = memWr &&  halfSel;

    strb.pageLoad  = ioWr && regAddrEq;
    strb.dirOk     = readHalfOk || writeHalfOk;
    strb.writeHalf = halfSel;
    strb.oddByte   = byteSel;
  end

endmodule

// File: rtl/mmio_ide_window_dp.sv
module mmio_ide_window_dp
  import mmio_ide_window_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int HI_W   = 10,
  parameter int DA_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PAGE_W-1:0] ioData,
  input  logic [HI_W-1:0]   hiAddr,
  input  winStrobe_t        strb,
  input  logic [DA_W-1:0]   portDa,
  output logic [PAGE_W-1:0] pageVal,
  output logic              windowHit,
  output logic              cs0N,
  output logic              cs1N,
  output logic [DA_W-1:0]   ideDa,
  output logic              latchLoad,
  output logic              latchDrive
);

  localparam int GAP_W = HI_W - PAGE_W;

  logic [PAGE_W-1:0] pageQ;
  logic              winEnable;
  logic              pageEq;
  logic              gapClear;
  logic              hit;
  logic              realXfer;

  // Page register: loaded from the I/O data byte.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageQ <= '0;
    end else if (strb.pageLoad) begin
      pageQ <= ioData;
    end
  end

  // Address bits between the page compare and the window offset must be 0.
  generate
    if (GAP_W > 0) begin : g_gap
      assign gapClear = ~|hiAddr[GAP_W-1:0];
    end else begin : g_nogap
      assign gapClear = 1'b1;
    end
  endgenerate

  always_comb begin
    winEnable = pageQ[PAGE_W-1];
    pageEq    = (hiAddr[HI_W-1 -: PAGE_W] == pageQ);
    hit       = winEnable && pageEq && gapClear && strb.dirOk;
    // Bit 0 picks transfer vs no-op; the write half reverses its sense.
    realXfer  = (strb.oddByte == strb.writeHalf);

    cs0N       = 1'b1;
    cs1N       = 1'b1;
    ideDa      = portDa;
    latchLoad  = 1'b0;
    latchDrive = 1'b0;
    if (hit) begin
      cs0N       = !realXfer;
      cs1N       =  realXfer;
      ideDa      = '0;
      latchLoad  = !strb.oddByte;
      latchDrive =  strb.oddByte;
    end
  end

  assign pageVal   = pageQ;
  assign windowHit = hit;

endmodule

// File: rtl/mmio_ide_window.sv
module mmio_ide_window
  import mmio_ide_window_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int PAGE_W   = 8,
  parameter int WIN_W    = 10,
  parameter int IO_W     = 10,
  parameter int DA_W     = 3,
  parameter logic [IO_W-1:0] IO_BASE = 10'h300,
  parameter int REG_OFFS = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] isaAddr,
  input  logic [PAGE_W-1:0] ioData,
  input  logic              memRd,
  input  logic              memWr,
  input  logic              ioWr,
  input  logic [DA_W-1:0]   portDa,
  output logic              cs0N,
  output logic              cs1N,
  output logic [DA_W-1:0]   ideDa,
  output logic              latchLoad,
  output logic              latchDrive,
  output logic              windowHit
);

  localparam int HI_W     = ADDR_W - WIN_W;
  localparam int HALF_BIT = WIN_W - 1;
  localparam logic [IO_W-1:0] REG_ADDR = IO_BASE + IO_W'(REG_OFFS);

  winStrobe_t        strb;
  logic [PAGE_W-1:0] pageVal;

  mmio_ide_window_ctrl #(
    .IO_W    (IO_W),
    .REG_ADDR(REG_ADDR)
  ) uCtrl (
    .ioAddr (isaAddr[IO_W-1:0]),
    .halfSel(isaAddr[HALF_BIT]),
    .byteSel(isaAddr[0]),
    .memRd  (memRd),
    .memWr  (memWr),
    .ioWr   (ioWr),
    .strb   (strb)
  );

  mmio_ide_window_dp #(
    .PAGE_W(PAGE_W),
    .HI_W  (HI_W),
    .DA_W  (DA_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ioData    (ioData),
    .hiAddr    (isaAddr[ADDR_W-1:WIN_W]),
    .strb      (strb),
    .portDa    (portDa),
    .pageVal   (pageVal),
    .windowHit (windowHit),
    .cs0N      (cs0N),
    .cs1N      (cs1N),
    .ideDa     (ideDa),
    .latchLoad (latchLoad),
    .latchDrive(latchDrive)
  );

endmodule

// File: rtl/mmio_ide_window_chk.sv
module mmio_ide_window_chk #(
  parameter int ADDR_W = 20,
  parameter int PAGE_W = 8,
  parameter int WIN_W  = 10,
  parameter int IO_W   = 10,
  parameter int DA_W   = 3,
  parameter logic [IO_W-1:0] REG_ADDR = 10'h30F
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] isaAddr,
  input logic [PAGE_W-1:0] ioData,
  input logic              memRd,
  input logic              memWr,
  input logic              ioWr,
  input logic [PAGE_W-1:0] pageVal,
  input logic              windowHit,
  input logic              cs0N,
  input logic              cs1N,
  input logic [DA_W-1:0]   ideDa,
  input logic              latchLoad,
  input logic              latchDrive
);

  logic regWrite;
  assign regWrite = ioWr && (isaAddr[IO_W-1:0] == REG_ADDR);

  // R1: page comes out of reset cleared
  assert_reset_page_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pageVal == '0));

  // R2: addressed I/O write loads the page on the next edge
  assert_page_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    regWrite |=> (pageVal == $past(ioData)));

  // R2: page holds without an addressed write
  assert_page_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !regWrite |=> $stable(pageVal));

  // R3: no hit while the enable bit is clear
  assert_hit_needs_enable_R3: assert property (@(posedge clk) disable iff (!rstN)
    windowHit |-> pageVal[PAGE_W-1]);

  // R4: a hit lies inside the page and the gap bits are zero
  assert_hit_in_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    windowHit |-> (isaAddr[ADDR_W-1 -: PAGE_W] == pageVal) &&
                  (isaAddr[ADDR_W-PAGE_W-1:WIN_W] == '0));

  // R5: the strobe direction agrees with the half
  assert_half_direction_R5: assert property (@(posedge clk) disable iff (!rstN)
    windowHit |-> (isaAddr[WIN_W-1] ? memWr : memRd));

  // R6: no memory strobe, no hit
  assert_needs_mem_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd || memWr) |-> !windowHit);

  // R7: exactly one select on a hit, the right one for the ordering
  assert_select_order_R7: assert property (@(posedge clk) disable iff (!rstN)
    windowHit |-> ((isaAddr[0] == isaAddr[WIN_W-1]) ? (!cs0N && cs1N)
                                                   : (cs0N && !cs1N)));

  // R8: data register selected on every hit
  assert_da_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    windowHit |-> (ideDa == '0));

  // R9: latch controls never overlap
  assert_latch_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({latchLoad, latchDrive}));

  // R9: a hit always steers the latch by address bit 0
  assert_latch_by_byte_R9: assert property (@(posedge clk) disable iff (!rstN)
    windowHit |-> (latchDrive == isaAddr[0]) && (latchLoad == !isaAddr[0]));

  // R10: outputs idle without a hit
  assert_idle_outputs_R10: assert property (@(posedge clk) disable iff (!rstN)
    !windowHit |-> cs0N && cs1N && !latchLoad && !latchDrive);

endmodule

bind mmio_ide_window mmio_ide_window_chk #(
  .ADDR_W  (ADDR_W),
  .PAGE_W  (PAGE_W),
  .WIN_W   (WIN_W),
  .IO_W    (IO_W),
  .DA_W    (DA_W),
  .REG_ADDR(REG_ADDR)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .isaAddr   (isaAddr),
  .ioData    (ioData),
  .memRd     (memRd),
  .memWr     (memWr),
  .ioWr      (ioWr),
  .pageVal   (pageVal),
  .windowHit (windowHit),
  .cs0N      (cs0N),
  .cs1N      (cs1N),
  .ideDa     (ideDa),
  .latchLoad (latchLoad),
  .latchDrive(latchDrive)
);

// File: tb/sim_mmio_ide_window.sv
module sim_mmio_ide_window;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] PORT_DA = 3'b101;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] isaAddr = '0;
  logic [7:0]  ioData = '0;
  logic        memRd = 1'b0;
  logic        memWr = 1'b0;
  logic        ioWr = 1'b0;
  logic [2:0]  portDa = PORT_DA;
  logic        cs0N, cs1N, latchLoad, latchDrive, windowHit;
  logic [2:0]  ideDa;

  int nChecks = 0;
  int nFail = 0;
  logic [7:0] modelPage = 8'h00;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmio_ide_window u0 (
    .clk(clk), .rstN(rstN), .isaAddr(isaAddr), .ioData(ioData),
    .memRd(memRd), .memWr(memWr), .ioWr(ioWr), .portDa(portDa),
    .cs0N(cs0N), .cs1N(cs1N), .ideDa(ideDa), .latchLoad(latchLoad),
    .latchDrive(latchDrive), .windowHit(windowHit)
  );

  // Expected {hit, cs0N, cs1N, da[2:0], latchLoad, latchDrive}
  function automatic logic [7:0] expect_out(logic [19:0] a, logic rd, logic wr);
    logic hit, xfer;
    logic [2:0] da;
    hit  = modelPage[7] && (a[19:12] == modelPage) && (a[11:10] == 2'b00) &&
           ((rd && !a[9]) || (wr && a[9]));
    xfer = (a[0] == a[9]);
    da   = hit ? 3'b000 : PORT_DA;
    if (!hit) return {1'b0, 1'b1, 1'b1, da, 1'b0, 1'b0};
    return {1'b1, !xfer, xfer, da, !a[0], a[0]};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    memRd = 1'b0; memWr = 1'b0; ioWr = 1'b0;
  endtask

  task automatic mem_access(string req, logic [19:0] a, logic rd, logic wr, logic io);
    @(negedge clk);
    isaAddr = a; memRd = rd; memWr = wr; ioWr = io;
    #1;
    check(req, {windowHit, cs0N, cs1N, ideDa, latchLoad, latchDrive},
          expect_out(a, rd, wr));
  endtask

  task automatic io_write(logic [9:0] port, logic [7:0] d);
    @(negedge clk);
    idle();
    isaAddr = {10'h000, port}; ioData = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
    if (port == 10'h30F) modelPage = d;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    modelPage = 8'h00;
  endtask

  task automatic t_reset();
    do_reset();
    // R1: page 00h with top bit clear, so address 00000h cannot hit
    mem_access("R1 reset no hit at 00000", 20'h00000, 1'b1, 1'b0, 1'b0);
    mem_access("R1 reset idle outputs R10", 20'h00200, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_disabled_page();
    io_write(10'h30F, 8'h58);
    // R3: page matches A19..A12 but the enable bit is clear
    mem_access("R3 disabled page read", 20'h58000, 1'b1, 1'b0, 1'b0);
    mem_access("R3 disabled page write", 20'h58201, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_load_and_foreign_io();
    io_write(10'h30F, 8'hD8);
    mem_access("R2 load D8 read hit", 20'hD8000, 1'b1, 1'b0, 1'b0);
    // R2: neighbouring port must not move the window
    io_write(10'h30E, 8'hC0);
    mem_access("R2 foreign port keeps window", 20'hD8000, 1'b1, 1'b0, 1'b0);
    mem_access("R2 foreign port no new window", 20'hC0000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_read_half();
    // R7 R8 R9: even read transfers, odd read is a no-op
    mem_access("R7 read even xfer", 20'hD8000, 1'b1, 1'b0, 1'b0);
    mem_access("R9 read odd noop", 20'hD8001, 1'b1, 1'b0, 1'b0);
    mem_access("R8 read top even", 20'hD81FE, 1'b1, 1'b0, 1'b0);
    mem_access("R4 read top odd", 20'hD81FF, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_write_half();
    mem_access("R7 write even noop", 20'hD8200, 1'b0, 1'b1, 1'b0);
    mem_access("R9 write odd xfer", 20'hD8201, 1'b0, 1'b1, 1'b0);
    mem_access("R4 write top odd", 20'hD83FF, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_direction();
    // R5: wrong strobe for the half
    mem_access("R5 write into read half", 20'hD8000, 1'b0, 1'b1, 1'b0);
    mem_access("R5 read from write half", 20'hD8201, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_bounds();
    mem_access("R4 gap bit A10 set", 20'hD8400, 1'b1, 1'b0, 1'b0);
    mem_access("R4 gap bit A11 set", 20'hD8A00, 1'b0, 1'b1, 1'b0);
    mem_access("R4 below window", 20'hD7FFF, 1'b1, 1'b0, 1'b0);
    mem_access("R4 page above", 20'hD9000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_io_no_hit();
    // R6: I/O write strobe alone, and no strobe, inside the window
    mem_access("R6 io strobe no hit", 20'hD8000, 1'b0, 1'b0, 1'b1);
    mem_access("R6 no strobe no hit", 20'hD8201, 1'b0, 1'b0, 1'b0);
    mem_access("R2 window after io strobe", 20'hD8000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_block_move();
    // R7 R9: ascending byte pairs alternate transfer/no-op per word
    for (int i = 0; i < 16; i++)
      mem_access("R7 block read", 20'hD8000 + 20'(i), 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++)
      mem_access("R9 block write", 20'hD8200 + 20'(i), 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_relocate();
    io_write(10'h30F, 8'h80);
    mem_access("R2 relocated hit", 20'h80201, 1'b0, 1'b1, 1'b0);
    mem_access("R4 old window gone", 20'hD8000, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_disabled_page();
    t_load_and_foreign_io();
    t_read_half();
    t_write_half();
    t_direction();
    t_bounds();
    t_io_no_hit();
    t_block_move();
    t_relocate();
    t_reset();
    @(negedge clk);
    idle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule